// File: doc/BRIEF.md
# Channel Calibration Sequencer

This block runs the four calibration commands of one measurement channel. A command code and a one-clock start strobe select the command. The block waits until a fresh computation cycle of the datapath begins. It then observes either the instantaneous sample stream or the RMS result at the end of that cycle, derives a new register value from that statistic, and writes it. The four commands and their statistics are:

- DC offset: the negated mean of the samples.
- AC offset: the squared RMS.
- DC gain: the reciprocal of the mean.
- AC gain: 0.6 divided by the RMS.

The datapath reads the three resulting registers directly. The two gain commands share one restoring divider that produces one quotient bit per clock.

Samples are signed two's complement in which 2^(SW-1) stands for full scale (1.0). The RMS input is unsigned on the same scale. The gain is unsigned with GF fraction bits, so 1.0 is 2^GF. The averaging window is N = 2^LOG2N valid samples.

The controller has six states:

- IDLE: waits for a start strobe and moves to ARM when one arrives.
- ARM: waits for the end-of-cycle pulse. On that pulse it moves to ACCUM for a DC command or to CAPT for an AC command.
- ACCUM: sums samples. It moves to EVAL when the N-th sample arrives.
- CAPT: moves to EVAL at the next end-of-cycle pulse, latching the RMS result.
- EVAL: writes the offset result and returns to IDLE. For a gain command it either aborts to IDLE or moves to DIV.
- DIV: returns to IDLE when the quotient is ready.

Top module: `chan_cal_seq`

## Requirements
- R1: After reset the outputs are: `dc_off` = 0, `ac_off` = 0, `gain` = 2^GF (1.0), `busy` = 0, `done` = 0 and `err` = 0.
- R2: `cmd` is sampled with `start` only while `busy` is low. The codes are 00 = DC offset, 01 = AC offset, 10 = DC gain and 11 = AC gain. `busy` is high in the cycle after an accepted start and stays high until the command ends. A `start` seen while `busy` is high has no effect.
- R3: Accepting a DC offset command sets `dc_off` to 0, `ac_off` to 0 and `gain` to 1.0. Accepting an AC offset command sets `ac_off` to 0 and `gain` to 1.0. Both changes are visible in the cycle after the start.
- R4: No data is used until the first `cyc_end` pulse after the start. Samples up to and including that pulse are ignored, and so is the RMS value presented with it.
- R5: DC offset writes the negation of floor(sum of the next N valid samples / N) to `dc_off`. When the mean is -2^(SW-1), the result saturates to 2^(SW-1)-1.
- R6: AC offset writes rms*rms, where rms is the value present at the second `cyc_end` after the start, to `ac_off` (2*SW bits).
- R7: DC gain writes floor(2^(GF+SW-1) / mean) to `gain`, where the mean is taken over N samples as in R5. An input equal to the calibration level then maps to full scale.
- R8: AC gain writes floor(round(0.6*2^(GF+SW-1)) / rms) to `gain`, using the RMS value captured as in R6.
- R9: A gain command aborts if the mean is 0 or less, if rms is 0, or if the quotient exceeds 2^GW-1. An abort writes nothing, gives no `done`, and sets `err`. `err` stays set until the next accepted start.
- R10: `done` is high for exactly one cycle, the cycle in which the written value first appears, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, one clock |
| cmd | input | 2 | Command code |
| smp_vld | input | 1 | Instantaneous sample valid |
| smp | input | SW | Signed instantaneous sample |
| cyc_end | input | 1 | Last clock of a computation cycle; `rms` is valid here |
| rms | input | SW | Unsigned RMS result |
| dc_off | output | SW | DC offset register (signed) |
| ac_off | output | 2*SW | AC offset register |
| gain | output | GW | Gain register, GF fraction bits |
| busy | output | 1 | Command in progress |
| done | output | 1 | Register written (one-clock pulse) |
| err | output | 1 | Last gain command aborted |

## Verification
The bench uses the defaults: SW = 16, LOG2N = 4 (16 samples), GW = 16 and GF = 14. This gives a gain range just below 4.0. A mean below about a quarter of full scale, or an RMS below about 0.15, therefore overflows the quotient and takes the abort path. Negative means, zero RMS and the full-negative DC offset saturation can all be reached with 16-sample windows. Random commands mixed with random sample ranges make every branch occur within a few thousand cycles.

// File: rtl/chan_cal_pkg.sv
package chan_cal_pkg;

    typedef enum logic [1:0] {
        CMD_DC_OFF  = 2'b00,
        CMD_AC_OFF  = 2'b01,
        CMD_DC_GAIN = 2'b10,
        CMD_AC_GAIN = 2'b11
    } cal_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_ACCUM,
        ST_CAPT,
        ST_EVAL,
        ST_DIV
    } cal_state_e;

endpackage

// File: rtl/cal_accum.sv
module cal_accum #(
    parameter int SW    = 16,
    parameter int LOG2N = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         en,
    input  logic signed [SW-1:0]         smp,
    output logic signed [SW+LOG2N-1:0]   sum,
    output logic                         last
);
    localparam int AW = SW + LOG2N;

    logic [LOG2N-1:0] cnt;

    // The N-th accepted sample of the window
    assign last = en && (cnt == {LOG2N{1'b1}});

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum <= '0;
            cnt <= '0;
        end else if (en) begin
            sum <= sum + AW'(smp);
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cal_div.sv
module cal_div #(
    parameter int NW = 30,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [NW-1:0] quo,
    output logic          vld
);
    localparam int CW = $clog2(NW + 1);

    logic [DW-1:0] rem;
    logic [DW-1:0] den_q;
    logic [CW-1:0] cnt;
    logic [DW:0]   trial;
    logic [DW:0]   diff;
    logic          fits;

    assign trial = {rem, quo[NW-1]};
    assign diff  = trial - {1'b0, den_q};
    assign fits  = trial >= {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            den_q <= '0;
            quo   <= '0;
            cnt   <= '0;
            vld   <= 1'b0;
        end else begin
            vld <= 1'b0;
            if (go) begin
                rem   <= '0;
                den_q <= den;
                quo   <= num;
                cnt   <= CW'(NW);
            end else if (cnt != '0) begin
                rem <= fits ? diff[DW-1:0] : trial[DW-1:0];
                quo <= {quo[NW-2:0], fits};
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) vld <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/chan_cal_seq.sv
module chan_cal_seq
    import chan_cal_pkg::*;
#(
    parameter int SW    = 16,
    parameter int LOG2N = 4,
    parameter int GW    = 16,
    parameter int GF    = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [1:0]             cmd,
    input  logic                   smp_vld,
    input  logic signed [SW-1:0]   smp,
    input  logic                   cyc_end,
    input  logic [SW-1:0]          rms,
    output logic signed [SW-1:0]   dc_off,
    output logic [2*SW-1:0]        ac_off,
    output logic [GW-1:0]          gain,
    output logic                   busy,
    output logic                   done,
    output logic                   err
);
    localparam int AW = SW + LOG2N;
    localparam int NW = GF + SW;
    localparam logic [GW-1:0] GAIN_ONE = GW'(1) << GF;
    localparam logic [NW-1:0] NUM_DC   = NW'(1) << (NW - 1);
    localparam logic [63:0]   NUM_AC64 = ((64'd6 << (NW - 1)) + 64'd5) / 64'd10;
    localparam logic [NW-1:0] NUM_AC   = NW'(NUM_AC64);
    localparam logic signed [SW-1:0] S_MIN = {1'b1, {(SW-1){1'b0}}};
    localparam logic signed [SW-1:0] S_MAX = {1'b0, {(SW-1){1'b1}}};

    cal_state_e state, nstate;
    cal_cmd_e   cmd_q;
    logic [SW-1:0] rms_q;

    logic signed [AW-1:0] acc_sum;
    logic                 acc_last;
    logic                 acc_clr, acc_en;

    logic signed [SW-1:0] mean_s;
    logic signed [SW-1:0] neg_mean;
    logic [SW-1:0]        den;
    logic                 den_ok;
    logic                 is_gain;
    logic                 div_go;
    logic [NW-1:0]        div_num;
    logic [NW-1:0]        div_quo;
    logic                 div_vld;
    logic                 quo_ovf;

    assign busy     = (state != ST_IDLE);
    assign acc_clr  = (state == ST_ARM);
    assign acc_en   = smp_vld && (state == ST_ACCUM);

    cal_accum #(.SW(SW), .LOG2N(LOG2N)) u_accum (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (acc_clr),
        .en   (acc_en),
        .smp  (smp),
        .sum  (acc_sum),
        .last (acc_last)
    );

    // Mean over the window (floor), and its saturated negation (R5)
    assign mean_s   = SW'(acc_sum >>> LOG2N);
    assign neg_mean = (mean_s == S_MIN) ? S_MAX : -mean_s;

    // Divisor and its validity for the gain commands (R7, R8, R9)
    assign is_gain = (cmd_q == CMD_DC_GAIN) || (cmd_q == CMD_AC_GAIN);
    always_comb begin
        if (cmd_q == CMD_DC_GAIN) begin
            den     = mean_s;
            den_ok  = (mean_s > 0);
            div_num = NUM_DC;
        end else begin
            den     = rms_q;
            den_ok  = (rms_q != '0);
            div_num = NUM_AC;
        end
    end

    assign div_go = (state == ST_EVAL) && is_gain && den_ok;

    cal_div #(.NW(NW), .DW(SW)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (div_num),
        .den  (den),
        .quo  (div_quo),
        .vld  (div_vld)
    );

    assign quo_ovf = (div_quo >> GW) != '0;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (start)    nstate = ST_ARM;
            ST_ARM:   if (cyc_end)  nstate = cmd_q[0] ? ST_CAPT : ST_ACCUM;
            ST_ACCUM: if (acc_last) nstate = ST_EVAL;
            ST_CAPT:  if (cyc_end)  nstate = ST_EVAL;
            ST_EVAL:  nstate = div_go ? ST_DIV : ST_IDLE;
            ST_DIV:   if (div_vld)  nstate = ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    // Registers and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dc_off <= '0;
            ac_off <= '0;
            gain   <= GAIN_ONE;
            done   <= 1'b0;
            err    <= 1'b0;
            cmd_q  <= CMD_DC_OFF;
            rms_q  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cmd_q <= cal_cmd_e'(cmd);
                        err   <= 1'b0;
                        // R3: raw-channel view for offset commands
                        if (cal_cmd_e'(cmd) == CMD_DC_OFF) begin
                            dc_off <= '0;
                            ac_off <= '0;
                            gain   <= GAIN_ONE;
                        end else if (cal_cmd_e'(cmd) == CMD_AC_OFF) begin
                            ac_off <= '0;
                            gain   <= GAIN_ONE;
                        end
                    end
                end
                ST_CAPT: if (cyc_end) rms_q <= rms;
                ST_EVAL: begin
                    unique case (cmd_q)
                        CMD_DC_OFF: begin
                            dc_off <= neg_mean;
                            done   <= 1'b1;
                        end
                        CMD_AC_OFF: begin
                            ac_off <= (2*SW)'(rms_q) * (2*SW)'(rms_q);
                            done   <= 1'b1;
                        end
                        default: if (!den_ok) err <= 1'b1;
                    endcase
                end
                ST_DIV: begin
                    if (div_vld) begin
                        if (quo_ovf) begin
                            err <= 1'b1;
                        end else begin
                            gain <= div_quo[GW-1:0];
                            done <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/chan_cal_seq_chk.sv
module chan_cal_seq_chk #(
    parameter int SW = 16,
    parameter int GW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic                 err,
    input logic [GW-1:0]        gain,
    input logic signed [SW-1:0] dc_off
);
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r9_abort_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($stable(gain) && !done));

    a_r3_gain_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (gain != $past(gain)) |-> (done || $past(start)));

    a_r5_dcoff_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_off != $past(dc_off)) |-> (done || $past(start)));
endmodule

bind chan_cal_seq chan_cal_seq_chk #(.SW(SW), .GW(GW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .err   (err),
    .gain  (gain),
    .dc_off(dc_off)
);

// File: tb/chan_cal_seq_test.sv
`timescale 1ns/1ps
module chan_cal_seq_test;
    localparam int SW = 16, LOG2N = 4, GW = 16, GF = 14, N = 16;
    localparam longint ONE    = 64'sd1 <<< GF;
    localparam longint NUM_DC = 64'sd1 <<< (GF + SW - 1);
    localparam longint NUM_AC = ((64'sd6 <<< (GF + SW - 1)) + 64'sd5) / 64'sd10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic smp_vld = 1'b0;
    logic signed [SW-1:0] smp = '0;
    logic cyc_end = 1'b0;
    logic [SW-1:0] rms = '0;
    logic signed [SW-1:0] dc_off;
    logic [2*SW-1:0] ac_off;
    logic [GW-1:0] gain;
    logic busy, done, err;

    always #10 clk = ~clk;

    chan_cal_seq #(.SW(SW), .LOG2N(LOG2N), .GW(GW), .GF(GF)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .smp_vld(smp_vld), .smp(smp), .cyc_end(cyc_end), .rms(rms),
        .dc_off(dc_off), .ac_off(ac_off), .gain(gain),
        .busy(busy), .done(done), .err(err)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    longint m_dc = 0, m_ac = 0, m_gain = ONE;
    logic signed [SW-1:0] buf_s [N];

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
        end
    end

    task automatic check(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic drv(logic signed [SW-1:0] s, logic ce, logic [SW-1:0] r);
        smp = s; smp_vld = 1'b1; cyc_end = ce; rms = r;
        tick();
        smp_vld = 1'b0; cyc_end = 1'b0;
    endtask

    task automatic fill_const(logic signed [SW-1:0] v);
        for (int i = 0; i < N; i++) buf_s[i] = v;
    endtask

    // One full command: start, an arming cycle of junk, the measured cycle, completion
    task automatic run_cal(logic [1:0] c, logic [SW-1:0] r_good, bit pre_chk,
                           bit inj, bit gaps, string tag_in);
        longint s, mean, q;
        bit exp_err, exp_done;
        string tag;
        int t;
        start = 1'b1; cmd = c;
        tick();
        start = 1'b0;
        check("R2", "busy after start", busy, 1);
        check("R9", "err cleared by start", err, 0);
        if (c == 2'b00) begin m_dc = 0; m_ac = 0; m_gain = ONE; end
        if (c == 2'b01) begin m_ac = 0; m_gain = ONE; end
        if (pre_chk) begin
            check("R3", "pre-clear gain", gain, m_gain);
            check("R3", "pre-clear ac_off", ac_off, m_ac);
            check("R3", "pre-clear dc_off", dc_off, m_dc);
        end
        // arming cycle (R4: all of this must be ignored)
        if (inj) begin start = 1'b1; cmd = ~c; end
        drv(-16'sd32768, 1'b0, 16'hFFFF);
        start = 1'b0;
        drv(-16'sd32768, 1'b0, 16'hFFFF);
        drv(-16'sd32768, 1'b1, 16'hFFFF);
        if (c[0] == 1'b0) begin
            for (int i = 0; i < N; i++) begin
                if (gaps && $urandom_range(1, 0) == 1) tick();
                drv(buf_s[i], (i == N - 1), 16'hFFFF);
            end
        end else begin
            drv(16'sd123, 1'b0, 16'hFFFF);
            drv(16'sd77, 1'b0, 16'hFFFF);
            drv(16'sd5, 1'b1, r_good);
        end
        t = 0;
        while (busy && t < 500) begin tick(); t++; end
        check("R10", "command finished", (t < 500), 1);
        // model
        s = 0;
        for (int i = 0; i < N; i++) s += longint'(buf_s[i]);
        mean = s >>> LOG2N;
        exp_err = 0;
        case (c)
            2'b00: begin m_dc = (mean == -32768) ? 32767 : -mean; tag = "R5"; end
            2'b01: begin m_ac = longint'(r_good) * longint'(r_good); tag = "R6"; end
            2'b10: begin
                tag = "R7";
                if (mean <= 0) exp_err = 1;
                else begin
                    q = NUM_DC / mean;
                    if (q > 65535) exp_err = 1; else m_gain = q;
                end
            end
            default: begin
                tag = "R8";
                if (r_good == 0) exp_err = 1;
                else begin
                    q = NUM_AC / longint'(r_good);
                    if (q > 65535) exp_err = 1; else m_gain = q;
                end
            end
        endcase
        if (exp_err) tag = "R9";
        if (tag_in != "") tag = tag_in;
        exp_done = !exp_err;
        check(tag, "done", done, exp_done);
        check(tag, "err", err, exp_err);
        check(tag, "dc_off", longint'(dc_off), m_dc);
        check(tag, "ac_off", ac_off, m_ac);
        check(tag, "gain", gain, m_gain);
        if (exp_done) begin
            tick();
            check("R10", "done single cycle", done, 0);
        end
    endtask

    initial begin
        logic [1:0] c;
        int k;
        logic [SW-1:0] r;
        void'($urandom(32'd20240611));
        repeat (3) tick();
        // R1: reset values
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "err", err, 0);
        check("R1", "gain", gain, ONE);
        check("R1", "dc_off", longint'(dc_off), 0);
        check("R1", "ac_off", ac_off, 0);
        rst_n = 1'b1;
        tick();

        // R4/R5: junk arming samples ignored, constant window
        fill_const(16'sd1000);
        run_cal(2'b00, 0, 1, 0, 0, "R4/R5");
        // R5 saturation at full negative
        fill_const(-16'sd32768);
        run_cal(2'b00, 0, 0, 0, 0, "");
        // R6: square of RMS captured after arming
        run_cal(2'b01, 16'd1000, 1, 0, 0, "");
        // R7: half scale mean gives 2.0
        fill_const(16'sd16384);
        run_cal(2'b10, 0, 0, 0, 1, "");
        // R8: 0.6 / 0.5
        run_cal(2'b11, 16'd16384, 0, 0, 0, "");
        // R9: aborts (negative mean, zero RMS, overflow)
        fill_const(-16'sd100);
        run_cal(2'b10, 0, 0, 0, 0, "");
        run_cal(2'b11, 16'd0, 0, 0, 0, "");
        fill_const(16'sd1000);
        run_cal(2'b10, 0, 0, 0, 0, "");
        // R3: pre-clear with a non-default gain and AC offset present
        run_cal(2'b01, 16'd300, 0, 0, 0, "");
        fill_const(16'sd20000);
        run_cal(2'b10, 0, 0, 0, 0, "");
        fill_const(-16'sd7);
        run_cal(2'b00, 0, 1, 0, 0, "R3");
        // R2: start with another command while busy is ignored
        fill_const(16'sd2500);
        run_cal(2'b00, 0, 0, 1, 0, "R2");

        // random commands and data
        for (int it = 0; it < 40; it++) begin
            c = 2'($urandom_range(3, 0));
            k = $urandom_range(3, 0);
            for (int i = 0; i < N; i++)
                buf_s[i] = (k == 0) ? SW'($urandom) : SW'($urandom_range(32767, 2000));
            r = (k == 0) ? SW'($urandom_range(6000, 0)) : SW'($urandom);
            run_cal(c, r, (k == 1), (k == 2), 1, "");
        end
        summary();
    end
endmodule